// File: doc/BRIEF.md
# Secondary Synchronisation Sequence Detector

This block finds the cell group and the half-frame position of a downlink cell from a single frequency-domain OFDM symbol. It sits after the OFDM demodulator and after primary sync detection. The demodulated subcarriers arrive as a stream, one per valid cycle, and a marker flags the first subcarrier of each symbol. After reset the block counts symbols. The first marked symbol is taken as symbol 0 of a subframe that carries the secondary sequence. From the sixth symbol it keeps the 62 subcarriers that sit around DC.

Once capture is complete, the block correlates the stored values against every candidate sequence, one candidate after another. Each candidate is built on the fly from three length-31 m-sequences. Its elements are all ±1, so the correlation uses only additions and subtractions. For each candidate the block forms the squared magnitude of the complex dot product and keeps the largest. The winning index gives the cell group, which the block combines with the sector index from primary sync to form the cell identity. The same index also says whether the symbol lay in subframe 0 or subframe 5.

A search takes 63 cycles per candidate. When it ends, a one-cycle done strobe marks the results, and they then stay stable until the next reset.

Top module: `sss_detector`

## Requirements
- R1: After reset, symbols are counted from the first sample that has both `in_valid` and `in_sym_start` high, which is symbol 0. Only symbol index 5 is captured. Samples before that first marker, and samples of every other symbol, have no effect on the result.
- R2: Within a symbol, sample position p counts valid samples from 0. The block captures sequence element n = p-(NFFT/2-31) for p in NFFT/2-31..NFFT/2-1, and n = p-NFFT/2+30 for p in NFFT/2+1..NFFT/2+31. The DC position NFFT/2 and all other positions are ignored.
- R3: Cycles with `in_valid` low are skipped and do not advance the position count.
- R4: Candidate k (0..2·GROUPS-1) has group g = k/2 and half h = k mod 2, where h=0 means subframe 0 and h=1 means subframe 5. Its element n, with j = n/2, is ±1 and is built from sequences s, c and z. These follow x(i+5) = x(i+2)⊕x(i), x(i+3)⊕x(i) and x(i+4)⊕x(i+2)⊕x(i+1)⊕x(i), with x(0..4)=0,0,0,0,1 and value 1-2x. The shifts are m0 = m' mod 31 and m1 = (m0+⌊m'/31⌋+1) mod 31, where m' = g+q(q+1)/2, q = ⌊(g+q'(q'+1)/2)/30⌋ and q' = ⌊g/30⌋. An even element for h=0 is s(j+m0)·c(j+N2); for h=1 it uses m1 in place of m0. An odd element for h=0 is s(j+m1)·c(j+N2+3)·z(j+(m0 mod 8)); for h=1 it is s(j+m0)·c(j+N2+3)·z(j+(m1 mod 8)). All indices are taken mod 31, and N2 is the sector.
- R5: The metric is Re²+Im² of Σ rx(n)·cand(n). The winner is the candidate with the largest metric. On a tie, the lowest k wins, so an all-zero capture yields k=0.
- R6: `cell_id` = 3·g + sector, using the winning g and the sector latched when capture completes. `sf5` equals the winning h.
- R7: `done` is high for exactly one cycle when the search ends. `cell_id` and `sf5` keep their values after it until the next reset.
- R8: Synchronous reset clears `done`, `cell_id` and `sf5` to 0. It aborts any search in progress and re-arms capture for a new symbol sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts and re-arms |
| in_valid | input | 1 | Qualifies the subcarrier sample |
| in_sym_start | input | 1 | First subcarrier of an OFDM symbol (with in_valid) |
| in_re | input | W | Real part of the subcarrier, signed |
| in_im | input | W | Imaginary part of the subcarrier, signed |
| sector_in | input | 2 | Sector index 0..2 from primary sync detection |
| done | output | 1 | One-cycle strobe at the end of the search |
| cell_id | output | 9 | Detected cell identity 0..503 |
| sf5 | output | 1 | 1 if the symbol lay in subframe 5, 0 if in subframe 0 |

## Verification
The assertions assume that `sector_in` holds a value of 0 to 2 in the cycle where capture completes. They also assume that sample magnitudes fit W bits, so that 62 accumulated terms cannot overflow the accumulator. The bench keeps `sector_in` steady over each whole run, and it always picks a legal value. It scales every sequence by amplitudes well inside the W-bit range. Between runs it puts bounded junk in the non-captured bins, in the other symbols and ahead of the first marker. In some runs it also leaves idle gaps in `in_valid`.

// File: rtl/sss_pkg.sv
package sss_pkg;

    localparam int SEQ_LEN = 31;
    localparam int SSS_LEN = 62;

    // feedback taps over x(i)..x(i+4), bit b selects x(i+b)
    localparam logic [4:0] TAP_S = 5'b00101;
    localparam logic [4:0] TAP_C = 5'b01001;
    localparam logic [4:0] TAP_Z = 5'b10111;

    typedef enum logic [2:0] {
        SR_IDLE,
        SR_ACC,
        SR_EVAL,
        SR_FIN,
        SR_HOLD
    } srch_state_e;

    typedef struct packed {
        logic [4:0] m0;
        logic [4:0] m1;
    } shift_pair_t;

    function automatic logic [30:0] mseq(input logic [4:0] taps);
        logic [30:0] x;
        x = 31'h10;
        for (int i = 0; i < 26; i++) begin
            x[i+5] = ^(x[i +: 5] & taps);
        end
        return x;
    endfunction

    localparam logic [30:0] SEQ_S = mseq(TAP_S);
    localparam logic [30:0] SEQ_C = mseq(TAP_C);
    localparam logic [30:0] SEQ_Z = mseq(TAP_Z);

    function automatic logic [4:0] wrap31(input logic [5:0] v);
        logic [5:0] t;
        t = v - 6'd31;
        return (v >= 6'd31) ? t[4:0] : v[4:0];
    endfunction

    function automatic shift_pair_t group_shifts(input int unsigned grp);
        int unsigned qp, q, mp, a, b;
        shift_pair_t sp;
        qp = grp / 30;
        q  = (grp + (qp * (qp + 1)) / 2) / 30;
        mp = grp + (q * (q + 1)) / 2;
        a  = mp % 31;
        b  = (a + mp / 31 + 1) % 31;
        sp.m0 = 5'(a);
        sp.m1 = 5'(b);
        return sp;
    endfunction

    // 1 when the candidate element is -1
    function automatic logic elem_neg(input shift_pair_t sp, input logic half,
                                      input logic [1:0] sector, input logic [5:0] n);
        logic [5:0] j6;
        logic [4:0] ma, mb;
        j6 = {1'b0, n[5:1]};
        ma = half ? sp.m1 : sp.m0;
        mb = half ? sp.m0 : sp.m1;
        if (!n[0]) begin
            return SEQ_S[wrap31(j6 + {1'b0, ma})] ^ SEQ_C[wrap31(j6 + {4'b0, sector})];
        end
        return SEQ_S[wrap31(j6 + {1'b0, mb})]
             ^ SEQ_C[wrap31(j6 + {4'b0, sector} + 6'd3)]
             ^ SEQ_Z[wrap31(j6 + {3'b0, ma[2:0]})];
    endfunction

endpackage

// File: rtl/sss_capture.sv
module sss_capture
    import sss_pkg::*;
#(
    parameter int NFFT    = 2048,
    parameter int W       = 16,
    parameter int SSS_SYM = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_sym_start,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    input  logic [5:0]          rd_idx,
    output logic signed [W-1:0] rd_re,
    output logic signed [W-1:0] rd_im,
    output logic                full
);
    localparam int PW   = $clog2(NFFT);
    localparam int HALF = NFFT / 2;
    localparam int LO   = HALF - 31;
    localparam int HI   = HALF + 31;
    localparam int SYW  = $clog2(SSS_SYM + 2);

    logic            started;
    logic [SYW-1:0]  sym_idx, sym_next, cur_sym;
    logic [PW-1:0]   smp_cnt, pos, off_lo, off_hi;
    logic [5:0]      cap_cnt, slot;
    logic            cur_ok, in_band, wr;

    logic signed [W-1:0] mem_re [SSS_LEN];
    logic signed [W-1:0] mem_im [SSS_LEN];

    always_comb begin
        sym_next = (sym_idx == SYW'(SSS_SYM + 1)) ? sym_idx : sym_idx + 1'b1;
        cur_ok   = in_sym_start || started;
        pos      = in_sym_start ? '0 : smp_cnt;
        cur_sym  = in_sym_start ? (started ? sym_next : '0) : sym_idx;
        in_band  = (pos >= PW'(LO)) && (pos <= PW'(HI)) && (pos != PW'(HALF));
        off_lo   = pos - PW'(LO);
        off_hi   = pos - PW'(HALF - 30);
        slot     = (pos < PW'(HALF)) ? off_lo[5:0] : off_hi[5:0];
        wr       = in_valid && cur_ok && (cur_sym == SYW'(SSS_SYM)) && in_band
                   && (cap_cnt < 6'(SSS_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
            sym_idx <= '0;
            smp_cnt <= '0;
            cap_cnt <= '0;
            full    <= 1'b0;
        end else begin
            full <= wr && (cap_cnt == 6'(SSS_LEN - 1));
            if (in_valid && cur_ok) begin
                started <= 1'b1;
                sym_idx <= cur_sym;
                smp_cnt <= pos + 1'b1;
            end
            if (wr) cap_cnt <= cap_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem_re[slot] <= in_re;
            mem_im[slot] <= in_im;
        end
    end

    assign rd_re = mem_re[rd_idx];
    assign rd_im = mem_im[rd_idx];

    p_cap_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cap_cnt <= 6'(SSS_LEN));

    p_full_once_r1: assert property (@(posedge clk) disable iff (rst)
        full |=> !full);

endmodule

// File: rtl/sss_seq_gen.sv
module sss_seq_gen
    import sss_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic [GW-1:0] group,
    input  logic          half,
    input  logic [1:0]    sector,
    input  logic [5:0]    n,
    output logic          neg
);
    shift_pair_t sp;

    always_comb begin
        sp  = group_shifts(int'(unsigned'(group)));
        neg = elem_neg(sp, half, sector, n);
    end

endmodule

// File: rtl/sss_search.sv
module sss_search
    import sss_pkg::*;
#(
    parameter int W      = 16,
    parameter int GROUPS = 168
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          sector_in,
    output logic [5:0]          rd_idx,
    input  logic signed [W-1:0] rd_re,
    input  logic signed [W-1:0] rd_im,
    output logic                done,
    output logic [8:0]          cell_id,
    output logic                sf5
);
    localparam int NCAND = 2 * GROUPS;
    localparam int KW    = $clog2(NCAND);
    localparam int GW    = KW - 1;
    localparam int AW    = W + 6;
    localparam int MW    = 2 * AW;

    srch_state_e          state;
    logic [KW-1:0]        k, best_k;
    logic [5:0]           n;
    logic [1:0]           sector_q;
    logic signed [AW-1:0] acc_re, acc_im, ext_re, ext_im;
    logic signed [MW-1:0] wide_re, wide_im, sq_re, sq_im, sq_sum;
    logic [MW-1:0]        metric, best_metric;
    logic                 neg;
    logic [8:0]           grp9;

    sss_seq_gen #(.GW(GW)) u_seq (
        .group  (k[KW-1:1]),
        .half   (k[0]),
        .sector (sector_q),
        .n      (n),
        .neg    (neg)
    );

    always_comb begin
        rd_idx  = n;
        ext_re  = AW'(rd_re);
        ext_im  = AW'(rd_im);
        wide_re = MW'(acc_re);
        wide_im = MW'(acc_im);
        sq_re   = wide_re * wide_re;
        sq_im   = wide_im * wide_im;
        sq_sum  = sq_re + sq_im;
        metric  = $unsigned(sq_sum);
        grp9    = 9'(best_k >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SR_IDLE;
            k           <= '0;
            n           <= '0;
            best_k      <= '0;
            best_metric <= '0;
            acc_re      <= '0;
            acc_im      <= '0;
            sector_q    <= '0;
            done        <= 1'b0;
            cell_id     <= '0;
            sf5         <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SR_IDLE: if (start) begin
                    sector_q <= sector_in;
                    k        <= '0;
                    n        <= '0;
                    acc_re   <= '0;
                    acc_im   <= '0;
                    state    <= SR_ACC;
                end
                SR_ACC: begin
                    acc_re <= neg ? acc_re - ext_re : acc_re + ext_re;
                    acc_im <= neg ? acc_im - ext_im : acc_im + ext_im;
                    if (n == 6'(SSS_LEN - 1)) state <= SR_EVAL;
                    else n <= n + 1'b1;
                end
                SR_EVAL: begin
                    if (k == '0 || metric > best_metric) begin
                        best_metric <= metric;
                        best_k      <= k;
                    end
                    acc_re <= '0;
                    acc_im <= '0;
                    n      <= '0;
                    if (k == KW'(NCAND - 1)) state <= SR_FIN;
                    else begin
                        k     <= k + 1'b1;
                        state <= SR_ACC;
                    end
                end
                SR_FIN: begin
                    done    <= 1'b1;
                    cell_id <= grp9 + {grp9[7:0], 1'b0} + 9'(sector_q);
                    sf5     <= best_k[0];
                    state   <= SR_HOLD;
                end
                default: ;
            endcase
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_best_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SR_EVAL && k != '0) |=> best_metric >= $past(best_metric));

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state == SR_ACC) |-> n < 6'(SSS_LEN));

    p_sector_legal_r6: assert property (@(posedge clk) disable iff (rst)
        start |-> sector_in <= 2'd2);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SR_HOLD && $past(state) == SR_HOLD) |-> $stable(cell_id) && $stable(sf5));

endmodule

// File: rtl/sss_detector.sv
module sss_detector
    import sss_pkg::*;
#(
    parameter int NFFT    = 2048,
    parameter int W       = 16,
    parameter int GROUPS  = 168,
    parameter int SSS_SYM = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_sym_start,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    input  logic [1:0]          sector_in,
    output logic                done,
    output logic [8:0]          cell_id,
    output logic                sf5
);
    logic [5:0]          rd_idx;
    logic signed [W-1:0] rd_re, rd_im;
    logic                cap_full;

    sss_capture #(.NFFT(NFFT), .W(W), .SSS_SYM(SSS_SYM)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sym_start (in_sym_start),
        .in_re        (in_re),
        .in_im        (in_im),
        .rd_idx       (rd_idx),
        .rd_re        (rd_re),
        .rd_im        (rd_im),
        .full         (cap_full)
    );

    sss_search #(.W(W), .GROUPS(GROUPS)) u_srch (
        .clk       (clk),
        .rst       (rst),
        .start     (cap_full),
        .sector_in (sector_in),
        .rd_idx    (rd_idx),
        .rd_re     (rd_re),
        .rd_im     (rd_im),
        .done      (done),
        .cell_id   (cell_id),
        .sf5       (sf5)
    );

    p_done_needs_capture_r1: assert property (@(posedge clk) disable iff (rst)
        cap_full |-> !done);

endmodule

// File: tb/tb_sss_detector.sv
module tb_sss_detector;
    localparam int NFFT   = 128;
    localparam int GROUPS = 8;
    localparam int W      = 12;
    localparam int HALF   = NFFT / 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_sym_start = 1'b0;
    logic signed [W-1:0] in_re = '0;
    logic signed [W-1:0] in_im = '0;
    logic [1:0]          sector_in = '0;
    logic                done;
    logic [8:0]          cell_id;
    logic                sf5;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sss_detector #(.NFFT(NFFT), .W(W), .GROUPS(GROUPS)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym_start(in_sym_start),
        .in_re(in_re), .in_im(in_im), .sector_in(sector_in),
        .done(done), .cell_id(cell_id), .sf5(sf5)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // +1/-1 value of sequence kind (0=s,1=c,2=z) at index idx mod 31
    function automatic int pm(input int kind, input int idx);
        int x[31];
        for (int i = 0; i < 4; i++) x[i] = 0;
        x[4] = 1;
        for (int i = 0; i < 26; i++) begin
            case (kind)
                0: x[i+5] = (x[i+2] + x[i]) % 2;
                1: x[i+5] = (x[i+3] + x[i]) % 2;
                default: x[i+5] = (x[i+4] + x[i+2] + x[i+1] + x[i]) % 2;
            endcase
        end
        return 1 - 2 * x[idx % 31];
    endfunction

    function automatic int cand(input int g, input int h, input int sec, input int n);
        int qp, q, mp, m0, m1, j;
        qp = g / 30;
        q  = (g + qp * (qp + 1) / 2) / 30;
        mp = g + q * (q + 1) / 2;
        m0 = mp % 31;
        m1 = (m0 + mp / 31 + 1) % 31;
        j  = n / 2;
        if (n % 2 == 0)
            return pm(0, j + (h == 1 ? m1 : m0)) * pm(1, j + sec);
        if (h == 0)
            return pm(0, j + m1) * pm(1, j + sec + 3) * pm(2, j + m0 % 8);
        return pm(0, j + m0) * pm(1, j + sec + 3) * pm(2, j + m1 % 8);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        in_sym_start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drive(input int g, input int h, input int sec, input int ar, input int ai,
                         input bit zero, input bit gaps);
        int v, n;
        sector_in = 2'(sec);
        // samples before the first marker must be ignored (R1)
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sym_start = 1'b0;
            in_re = W'(700 - i * 90); in_im = W'(-300 + i * 50);
        end
        for (int s = 0; s < 7; s++) begin
            for (int p = 0; p < NFFT; p++) begin
                @(negedge clk);
                if (gaps && (p % 3 == 2)) begin
                    in_valid = 1'b0; in_sym_start = 1'b0;
                    in_re = W'(999); in_im = W'(-999);
                    @(negedge clk);
                end
                n = -1;
                if (p >= HALF - 31 && p < HALF) n = p - (HALF - 31);
                if (p > HALF && p <= HALF + 31) n = p - HALF + 30;
                in_valid = 1'b1;
                in_sym_start = (p == 0);
                if (s == 5 && n >= 0) begin
                    v = zero ? 0 : cand(g, h, sec, n);
                    in_re = W'(ar * v);
                    in_im = W'(ai * v);
                end else begin
                    v = ((p * 29 + s * 53 + g * 7) % 401) - 200;
                    in_re = W'(v);
                    in_im = W'(-v / 2);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sym_start = 1'b0;
    endtask

    task automatic finish_case(input string req, input int exp_cell, input int exp_half);
        bit ok = 1'b0;
        for (int i = 0; i < 6000 && !ok; i++) begin
            @(negedge clk);
            if (done) ok = 1'b1;
        end
        chk("R7", "done strobe seen", int'(ok), 1);
        if (ok) begin
            chk(req, "cell_id", int'(cell_id), exp_cell);
            chk(req, "sf5", int'(sf5), exp_half);
            @(negedge clk);
            chk("R7", "done single cycle", int'(done), 0);
            chk("R7", "cell_id held", int'(cell_id), exp_cell);
        end
    endtask

    task automatic run_case(input string req, input int g, input int h, input int sec,
                            input bit zero, input bit gaps);
        int ar, ai;
        ar = 120 + (g * 37 + h * 11) % 800;
        ai = -(60 + (g * 13 + h * 211) % 600);
        do_reset();
        drive(g, h, sec, ar, ai, zero, gaps);
        if (zero) finish_case(req, sec, 0);
        else      finish_case(req, 3 * g + sec, h);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired: actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R8", "reset done", int'(done), 0);
        chk("R8", "reset cell_id", int'(cell_id), 0);
        chk("R8", "reset sf5", int'(sf5), 0);

        // R4/R6: sweep every candidate of the small configuration, all sectors
        for (int g = 0; g < GROUPS; g++)
            for (int h = 0; h < 2; h++)
                run_case("R4", g, h, (g + h) % 3, 1'b0, 1'b0);

        // R3: idle gaps in the valid stream
        run_case("R3", 3, 1, 2, 1'b0, 1'b1);
        run_case("R3", 6, 0, 0, 1'b0, 1'b1);

        // R1/R2: junk in other symbols, bins and before the marker
        run_case("R2", 7, 1, 1, 1'b0, 1'b0);

        // R5: all-zero capture ties every metric, lowest index wins
        run_case("R5", 6, 1, 2, 1'b1, 1'b0);

        // R6: every sector for one group
        for (int sc = 0; sc < 3; sc++) run_case("R6", 5, 0, sc, 1'b0, 1'b0);

        // R8: abort a search midway, then a fresh search
        do_reset();
        drive(2, 1, 1, 400, 250, 1'b0, 1'b0);
        repeat (150) @(negedge clk);
        chk("R8", "no done before abort", int'(done), 0);
        do_reset();
        @(negedge clk);
        chk("R8", "done cleared by abort", int'(done), 0);
        chk("R8", "cell_id cleared by abort", int'(cell_id), 0);
        drive(4, 0, 2, 333, -222, 1'b0, 1'b0);
        finish_case("R8", 14, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule